// File: doc/BRIEF.md
# Store Buffer with Load Bypass and Fence Drain

This block sits between an in-order processor memory port and a single-ported memory. Stores are accepted into a small queue at once and written to memory later, strictly one at a time and in the order they were issued. Loads do not wait for those writes. A load whose address is already in the queue takes its data from the youngest queued store with that address. Any other load goes to memory ahead of the queued stores. The processor therefore never waits for a store to be performed, unless the queue is full or it asks for a fence.

A fence request is held off until every older access has finished: the queue is empty and no load is waiting on memory. The processor side is a valid/ready request port with an opcode, an address and write data, plus a one-cycle read response. The memory side is a request/acknowledge port. It holds its request until the acknowledge arrives, and the acknowledge may come after any number of cycles.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset no memory request is raised, no response is given, the queue is empty, and load and fence requests see `req_ready` high.
- R2: Opcode encoding on `req_op`: 2'b00 load, 2'b01 store, 2'b10 fence. Queued stores are written to memory in issue order, one at a time. Address and data stay steady until `mem_ack`, and the entry leaves the queue only on that acknowledge.
- R3: Two stores to the same address are never merged. Each produces its own memory write.
- R4: A load whose full word address matches one or more queued stores returns the data of the youngest match, with `rsp_valid` in the cycle after acceptance and no memory read.
- R5: A load that matches nothing reads memory, even while older stores are still queued. Its data appears with `rsp_valid` in the cycle after `mem_ack`.
- R6: When the memory port is free and both a missed load and a queued store are waiting, the load is issued first. A store already presented to memory is kept until its acknowledge.
- R7: When the queue holds the configured number of entries (default 4), a store sees `req_ready` low, but a load is still accepted.
- R8: A fence is accepted only when the queue is empty and no load is outstanding. Until then `req_ready` stays low for it.
- R9: While a missed load waits on memory, no further request of any kind is accepted.
- R10: A queued store does not change the memory contents before the memory acknowledges that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 00 load, 01 store, 10 fence |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
The hardest case to reach is the port contention between a missed load and a queued store. It only occurs in the idle cycle right after a store's acknowledge, when a load is already waiting. The bench sets the memory model to a long, fixed latency and queues three stores back to back. It then issues a missed load while the first write is still in flight, and checks that exactly one write came before the read. A full queue is reached the same way, using a latency longer than the time taken to issue four stores.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;

    parameter int unsigned SB_ADDR_W = 16;
    parameter int unsigned SB_DATA_W = 32;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FENCE = 2'd2
    } sb_op_e;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_STORE,
        PORT_LOAD
    } port_state_e;

    typedef struct packed {
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
    } sb_entry_t;

    function automatic logic entry_match(sb_entry_t e, logic [SB_ADDR_W-1:0] a);
        return e.addr == a;
    endfunction

endpackage

// File: rtl/tso_sb_queue.sv
module tso_sb_queue
    import tso_sb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  sb_entry_t            push_entry,
    input  logic                 pop,
    output sb_entry_t            head,
    output logic                 empty,
    output logic                 full,
    input  logic [SB_ADDR_W-1:0] look_addr,
    output logic                 look_hit,
    output logic [SB_DATA_W-1:0] look_data
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    sb_entry_t           slots [DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0]    count;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (int'(count) == DEPTH);

    // Walk oldest to youngest; a later hit overrides, leaving the youngest.
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            s = int'(rd_ptr) + i;
            if (s >= DEPTH) s = s - DEPTH;
            if (i < int'(count) && entry_match(slots[PTR_W'(s)], look_addr)) begin
                look_hit  = 1'b1;
                look_data = slots[PTR_W'(s)].data;
            end
        end
    end

    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_pop_empty_R2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/tso_sb_port.sv
module tso_sb_port
    import tso_sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_wait,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic                 st_avail,
    input  sb_entry_t            st_head,
    input  logic                 mem_ack,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [SB_ADDR_W-1:0] mem_addr,
    output logic [SB_DATA_W-1:0] mem_wdata,
    output logic                 st_done,
    output logic                 ld_done
);
    port_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PORT_IDLE:  if (ld_wait) state_nx = PORT_LOAD;
                        else if (st_avail) state_nx = PORT_STORE;
            PORT_STORE: if (mem_ack) state_nx = PORT_IDLE;
            PORT_LOAD:  if (mem_ack) state_nx = PORT_IDLE;
            default:    state_nx = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PORT_IDLE;
        else     state <= state_nx;
    end

    assign mem_req   = (state != PORT_IDLE);
    assign mem_we    = (state == PORT_STORE);
    assign mem_addr  = (state == PORT_STORE) ? st_head.addr : ld_addr;
    assign mem_wdata = (state == PORT_STORE) ? st_head.data : '0;
    assign st_done   = (state == PORT_STORE) && mem_ack;
    assign ld_done   = (state == PORT_LOAD) && mem_ack;

    assert_load_first_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PORT_IDLE && ld_wait) |=> (state == PORT_LOAD));
    assert_store_held_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_ack) |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)));
    assert_store_drains_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PORT_IDLE && st_avail && !ld_wait) |=> (mem_req && mem_we));

endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
    import tso_sb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [SB_ADDR_W-1:0] req_addr,
    input  logic [SB_DATA_W-1:0] req_wdata,
    output logic                 rsp_valid,
    output logic [SB_DATA_W-1:0] rsp_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [SB_ADDR_W-1:0] mem_addr,
    output logic [SB_DATA_W-1:0] mem_wdata,
    input  logic                 mem_ack,
    input  logic [SB_DATA_W-1:0] mem_rdata
);
    logic                 q_empty, q_full, q_hit, q_pop;
    logic [SB_DATA_W-1:0] q_hit_data;
    sb_entry_t            q_head, q_in;
    logic                 ld_wait, ld_done;
    logic [SB_ADDR_W-1:0] ld_addr;
    logic                 accept, is_load, is_store, is_fence;

    assign is_load  = (req_op == OP_LOAD);
    assign is_store = (req_op == OP_STORE);
    assign is_fence = (req_op == OP_FENCE);

    always_comb begin
        req_ready = 1'b0;
        if (!ld_wait) begin
            if (is_store)      req_ready = !q_full;
            else if (is_fence) req_ready = q_empty;
            else               req_ready = 1'b1;
        end
    end

    assign accept = req_valid && req_ready;
    assign q_in   = '{addr: req_addr, data: req_wdata};

    tso_sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (accept && is_store),
        .push_entry (q_in),
        .pop        (q_pop),
        .head       (q_head),
        .empty      (q_empty),
        .full       (q_full),
        .look_addr  (req_addr),
        .look_hit   (q_hit),
        .look_data  (q_hit_data)
    );

    tso_sb_port u_port (
        .clk       (clk),
        .rst       (rst),
        .ld_wait   (ld_wait),
        .ld_addr   (ld_addr),
        .st_avail  (!q_empty),
        .st_head   (q_head),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .st_done   (q_pop),
        .ld_done   (ld_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_wait   <= 1'b0;
            ld_addr   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (ld_done) begin
                ld_wait   <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_rdata <= mem_rdata;
            end else if (accept && is_load) begin
                if (q_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= q_hit_data;
                end else begin
                    ld_wait <= 1'b1;
                    ld_addr <= req_addr;
                end
            end
        end
    end

    assert_fence_drained_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && is_fence) |-> (q_empty && !ld_wait && !mem_req));
    assert_full_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_store && q_full) |-> !req_ready);
    assert_hit_no_read_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && is_load && q_hit) |=> (rsp_valid && !(mem_req && !mem_we)));
    assert_single_load_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !accept);

endmodule

// File: tb/tso_store_buffer_tb.sv
module tso_store_buffer_tb;
    import tso_sb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 4'd2, 32'h0000_1111},
        '{2'd0, 4'd2, 32'h0},
        '{2'd0, 4'd3, 32'h0},
        '{2'd1, 4'd3, 32'h0000_3333},
        '{2'd1, 4'd2, 32'h0000_2222},
        '{2'd0, 4'd2, 32'h0},
        '{2'd0, 4'd3, 32'h0},
        '{2'd2, 4'd0, 32'h0},
        '{2'd0, 4'd2, 32'h0},
        '{2'd1, 4'd15, 32'hFFFF_0000},
        '{2'd0, 4'd0, 32'h0},
        '{2'd0, 4'd15, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tso_store_buffer #(.DEPTH(4)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model with programmable latency and a write log.
    logic [31:0] mem_m [16];
    logic [15:0] wlog_a [32];
    logic [31:0] wlog_d [32];
    int lat = 2;
    int cnt = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int wr_at_rd = 0;

    assign mem_rdata = mem_m[mem_addr[3:0]];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            cnt <= 0;
            for (int i = 0; i < 16; i++) mem_m[i] <= 32'hA000_0000 | i;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            cnt <= 0;
            if (mem_we) begin
                mem_m[mem_addr[3:0]] <= mem_wdata;
                if (wr_cnt < 32) begin
                    wlog_a[wr_cnt] <= mem_addr;
                    wlog_d[wr_cnt] <= mem_wdata;
                end
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
                wr_at_rd <= wr_cnt;
            end
        end else if (mem_req) begin
            if (cnt >= lat - 1) mem_ack <= 1'b1;
            else cnt <= cnt + 1;
        end
    end

    logic [31:0] shadow [16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (op == 2'd1) shadow[a[3:0]] = d;
    endtask

    task automatic do_load(input logic [15:0] a, output logic [31:0] d);
        issue(2'd0, a, 32'h0);
        while (!rsp_valid) @(negedge clk);
        d = rsp_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w0, r0;
        for (int i = 0; i < 16; i++) shadow[i] = 32'hA000_0000 | i;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        req_op = 2'd0; #1;
        check("R1 load ready", {31'd0, req_ready}, 32'd1);
        req_op = 2'd2; #1;
        check("R1 fence ready", {31'd0, req_ready}, 32'd1);

        // Vector table walk; loads checked against program-order shadow (R4,R5)
        lat = 2;
        for (int k = 0; k < NVEC; k++) begin
            if (VECS[k].op == 2'd0) begin
                do_load({12'd0, VECS[k].addr}, d);
                check($sformatf("R4,R5 vec %0d", k), d, shadow[VECS[k].addr]);
            end else begin
                issue(VECS[k].op, {12'd0, VECS[k].addr}, VECS[k].data);
            end
        end
        issue(2'd2, 16'd0, 32'd0);

        // R2 / R3: program-order drain, no merge
        lat = 3;
        w0 = wr_cnt;
        issue(2'd1, 16'd5, 32'h11);
        issue(2'd1, 16'd5, 32'h22);
        issue(2'd1, 16'd6, 32'h33);
        issue(2'd2, 16'd0, 32'd0);
        check("R3 write count", wr_cnt - w0, 32'd3);
        check("R2 order addr0", {16'd0, wlog_a[w0]}, 32'd5);
        check("R3 order data0", wlog_d[w0], 32'h11);
        check("R3 order data1", wlog_d[w0+1], 32'h22);
        check("R2 order data2", wlog_d[w0+2], 32'h33);

        // R10: not visible before acknowledge
        lat = 8;
        d = mem_m[7];
        issue(2'd1, 16'd7, 32'h77);
        repeat (3) @(negedge clk);
        check("R10 not yet written", mem_m[7], d);
        issue(2'd2, 16'd0, 32'd0);
        check("R10 written", mem_m[7], 32'h77);

        // R4: youngest match forwarded, no memory read
        lat = 10;
        issue(2'd1, 16'd8, 32'h81);
        issue(2'd1, 16'd8, 32'h82);
        issue(2'd1, 16'd9, 32'h90);
        r0 = rd_cnt;
        issue(2'd0, 16'd8, 32'd0);
        check("R4 rsp next cycle", {31'd0, rsp_valid}, 32'd1);
        check("R4 youngest data", rsp_rdata, 32'h82);
        issue(2'd2, 16'd0, 32'd0);
        check("R4 no mem read", rd_cnt - r0, 32'd0);

        // R5 / R6: missed load overtakes queued stores
        lat = 6;
        w0 = wr_cnt;
        issue(2'd1, 16'd1, 32'h101);
        issue(2'd1, 16'd2, 32'h102);
        issue(2'd1, 16'd3, 32'h103);
        do_load(16'd12, d);
        check("R5 miss data", d, shadow[12]);
        check("R5 overtook stores", {31'd0, (wr_cnt - w0) < 3}, 32'd1);
        check("R6 read after one write", wr_at_rd - w0, 32'd1);
        issue(2'd2, 16'd0, 32'd0);
        check("R6 stores completed", wr_cnt - w0, 32'd3);

        // R7 / R8: full queue, load still accepted, fence waits
        lat = 15;
        w0 = wr_cnt;
        issue(2'd1, 16'd10, 32'hA10);
        issue(2'd1, 16'd11, 32'hA11);
        issue(2'd1, 16'd12, 32'hA12);
        issue(2'd1, 16'd13, 32'hA13);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'd14; req_wdata = 32'hA14;
        #1 check("R7 store stalled", {31'd0, req_ready}, 32'd0);
        req_op = 2'd0; req_addr = 16'd11;
        #1 check("R7 load accepted", {31'd0, req_ready}, 32'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R7 load hit", rsp_rdata, 32'hA11);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2;
        #1 check("R8 fence held", {31'd0, req_ready}, 32'd0);
        while (!req_ready) begin @(negedge clk); #1; end
        check("R8 fence after drain", wr_cnt - w0, 32'd4);
        @(posedge clk); #1;
        req_valid = 1'b0;

        // R9: nothing accepted while a missed load waits
        lat = 8;
        r0 = rd_cnt;
        issue(2'd0, 16'd4, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 16'd4; req_wdata = 32'h44;
        #1 check("R9 store blocked", {31'd0, req_ready}, 32'd0);
        while (!req_ready) begin @(negedge clk); #1; end
        check("R9 load done first", rd_cnt - r0, 32'd1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        shadow[4] = 32'h44;
        issue(2'd2, 16'd0, 32'd0);

        // R2: final memory image equals program-order image
        for (int i = 0; i < 16; i++) check($sformatf("R2 final mem %0d", i), mem_m[i], shadow[i]);

        summary();
        $finish;
    end

endmodule